// File: doc/BRIEF.md
# I2C Slave Front End with High-Speed Mode Tracking

This block is the receive side of an I2C target. SCL and SDA are sampled by a fast system clock. From those samples the block finds START, repeated START and STOP conditions. It then shifts in bytes MSB first and compares the first byte after any START against its 7-bit device address and the direction bit. When it acknowledges, it pulls SDA low through an open-drain enable.

A byte of the form `00001xxx` received directly after a START is a high-speed master code. The block never acknowledges such a byte. After the not-acknowledge clock it raises a flag that marks the bus as being in high-speed mode. Repeated STARTs leave the flag set, and only a STOP clears it. Each data byte of an addressed write is acknowledged and passed downstream as a one-cycle valid pulse with the byte. Downstream logic also receives single-cycle start and stop event pulses. A read address is acknowledged, but the block returns no data: SDA stays released.

Top module: `i2c_hs_slave`

## Requirements
- R1: `start_evt` pulses for one cycle on each START or repeated START (SDA falls while SCL is high), and `stop_evt` pulses for one cycle on each STOP (SDA rises while SCL is high). The two never pulse together.
- R2: A first byte after START whose upper five bits are `00001` is a master code, whatever its low three bits. `sda_oe` stays 0 through its ninth clock, so the master sees a not-acknowledge.
- R3: `hs_mode` goes to 1 when SCL falls at the end of the not-acknowledge clock that follows a master code.
- R4: `hs_mode` stays 1 through repeated STARTs and the transfers that follow them. It returns to 0 only on a STOP.
- R5: A first byte whose upper seven bits equal `DEV_ADDR` is acknowledged: `sda_oe` is 1 during the ninth clock. Bit 0 is the direction, with 0 meaning write. `addr_write` is 1 for a matched write.
- R6: A first byte that is neither a master code nor a match is not acknowledged. No byte is acknowledged or delivered after it until the next START or STOP.
- R7: In a matched write, each later byte is acknowledged and delivered MSB first on `byte_data`, together with a one-cycle `byte_valid` pulse.
- R8: A matched read address is acknowledged and `addr_write` stays 0. After that, `sda_oe` stays 0 until the next START or STOP.
- R9: `sda_oe` only rises while the synchronized SCL is low.
- R10: While reset is held and directly after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| byte_valid | output | 1 | One-cycle pulse: `byte_data` holds a new write byte |
| byte_data | output | 8 | Last received write data byte |
| start_evt | output | 1 | One-cycle pulse on START or repeated START |
| stop_evt | output | 1 | One-cycle pulse on STOP |
| addr_write | output | 1 | The current transfer is a matched write |
| hs_mode | output | 1 | Bus is in high-speed mode |

## Verification
The assertions check on every cycle that:
- start and stop events never coincide;
- the high-speed flag falls only together with a stop event and rises only while SCL is low;
- `byte_valid` is a single-cycle pulse that appears only inside a matched write;
- the acknowledge drive is switched on only while SCL is low.

Some behaviour can only be shown by the bench scenarios, because it depends on the sequence of bytes on the bus:
- the master code is never acknowledged, whatever its low bits;
- the flag survives repeated STARTs;
- a foreign address silences the rest of a transfer;
- a read address gets an acknowledge and then nothing more;
- bytes arrive intact and in MSB-first order.

// File: rtl/i2c_hs_pkg.sv
// Package: shared types and constants for the I2C high-speed-aware slave.
// Assumes: the master-code prefix is fixed by the bus protocol.
package i2c_hs_pkg;

    // Upper five bits that mark a high-speed master code
    localparam logic [4:0] MC_PREFIX = 5'b00001;

    // Transfer engine states
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_SHIFT,
        XS_ACK_WAIT,
        XS_ACK_HOLD,
        XS_IGNORE
    } xfer_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous lines.
// Assumes: lines idle high (the I2C bus is pulled up), so reset loads ones.
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw lines through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
// Module: decodes START, STOP and SCL edges from synchronized line levels.
// Assumes: inputs are already synchronized to clk; outputs are single-cycle.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    // Hold the previous sample of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decode against the previous sample
    always_comb begin
        start_det = scl_q & scl_s & sda_q & ~sda_s;
        stop_det  = scl_q & scl_s & ~sda_q & sda_s;
        scl_rise  = ~scl_q & scl_s;
        scl_fall  = scl_q & ~scl_s;
    end

endmodule

// File: rtl/i2c_hs_xfer.sv
// Module: byte shifter, address / master-code decode, acknowledge and
// high-speed flag.
// Assumes: single-cycle event strobes from i2c_bus_events; STOP outranks START.
module i2c_hs_xfer
    import i2c_hs_pkg::*;
#(
    parameter int         ADDR_W   = 7,
    parameter logic [6:0] DEV_ADDR = 7'h3C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       scl_rise,
    input  logic       scl_fall,
    output logic       sda_oe,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       start_evt,
    output logic       stop_evt,
    output logic       addr_write,
    output logic       hs_mode
);

    localparam int BITS  = ADDR_W + 1;
    localparam int CNT_W = $clog2(BITS);

    xfer_state_t      state;
    logic [BITS-1:0]  shreg;
    logic [BITS-1:0]  nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic             first_byte;
    logic             ack_pend;
    logic             mc_pend;
    logic             cont;

    // Byte as it will stand after the bit on the current rising edge
    assign nxt = {shreg[BITS-2:0], sda_s};

    // Transfer sequencing, acknowledge drive and mode tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= XS_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            first_byte <= 1'b0;
            ack_pend   <= 1'b0;
            mc_pend    <= 1'b0;
            cont       <= 1'b0;
            sda_oe     <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            start_evt  <= 1'b0;
            stop_evt   <= 1'b0;
            addr_write <= 1'b0;
            hs_mode    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            start_evt  <= 1'b0;
            stop_evt   <= 1'b0;
            if (stop_det) begin
                state      <= XS_IDLE;
                sda_oe     <= 1'b0;
                stop_evt   <= 1'b1;
                addr_write <= 1'b0;
                hs_mode    <= 1'b0;
            end else if (start_det) begin
                state      <= XS_SHIFT;
                bit_cnt    <= '0;
                first_byte <= 1'b1;
                sda_oe     <= 1'b0;
                start_evt  <= 1'b1;
                addr_write <= 1'b0;
            end else begin
                case (state)
                    XS_SHIFT: begin
                        if (scl_rise) begin
                            shreg <= nxt;
                            if (bit_cnt == CNT_W'(BITS - 1)) begin
                                bit_cnt <= '0;
                                state   <= XS_ACK_WAIT;
                                if (first_byte) begin
                                    if (nxt[7:3] == MC_PREFIX) begin
                                        ack_pend <= 1'b0;
                                        mc_pend  <= 1'b1;
                                        cont     <= 1'b0;
                                    end else if (nxt[BITS-1:1] == DEV_ADDR) begin
                                        ack_pend   <= 1'b1;
                                        mc_pend    <= 1'b0;
                                        cont       <= ~nxt[0];
                                        addr_write <= ~nxt[0];
                                    end else begin
                                        ack_pend <= 1'b0;
                                        mc_pend  <= 1'b0;
                                        cont     <= 1'b0;
                                    end
                                end else begin
                                    byte_valid <= 1'b1;
                                    byte_data  <= nxt;
                                    ack_pend   <= 1'b1;
                                    mc_pend    <= 1'b0;
                                    cont       <= 1'b1;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    XS_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= ack_pend;
                            state  <= XS_ACK_HOLD;
                        end
                    end
                    XS_ACK_HOLD: begin
                        if (scl_fall) begin
                            sda_oe     <= 1'b0;
                            first_byte <= 1'b0;
                            if (mc_pend) begin
                                hs_mode <= 1'b1;
                                state   <= XS_IGNORE;
                            end else if (cont) begin
                                state <= XS_SHIFT;
                            end else begin
                                state <= XS_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_hs_slave.sv
// Module: top of the I2C slave front end with high-speed mode tracking.
// Assumes: clk is several times faster than SCL; SDA is open-drain, and
// sda_oe=1 pulls it low.
module i2c_hs_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h3C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       start_evt,
    output logic       stop_evt,
    output logic       addr_write,
    output logic       hs_mode
);

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       start_det;
    logic       stop_det;
    logic       scl_rise;
    logic       scl_fall;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_hs_xfer #(.ADDR_W(7), .DEV_ADDR(DEV_ADDR)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_oe     (sda_oe),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_write (addr_write),
        .hs_mode    (hs_mode)
    );

endmodule

// File: rtl/i2c_hs_slave_chk.sv
// Module: protocol checker bound to i2c_hs_slave.
// Assumes: scl_s is the synchronized SCL inside the top module.
module i2c_hs_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic byte_valid,
    input logic start_evt,
    input logic stop_evt,
    input logic addr_write,
    input logic hs_mode
);

    assert_start_stop_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_evt && stop_evt));

    assert_hs_entry_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> !$past(scl_s));

    assert_hs_exit_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode) |-> stop_evt);

    assert_valid_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> addr_write);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_ack_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

endmodule

bind i2c_hs_slave i2c_hs_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_oe     (sda_oe),
    .byte_valid (byte_valid),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .addr_write (addr_write),
    .hs_mode    (hs_mode)
);

// File: tb/i2c_hs_slave_bench.sv
// Bench: drives an open-drain I2C master model against i2c_hs_slave.
module i2c_hs_slave_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 20;
    localparam int         WDOG_LIMIT = 150000;
    localparam logic [6:0] ADDR       = 7'h3C;
    localparam int         NVEC       = 6;
    localparam logic [7:0] WR_VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h5A, 8'h81, 8'h3C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       start_evt;
    logic       stop_evt;
    logic       addr_write;
    logic       hs_mode;

    int errors = 0;
    int checks = 0;
    int n_start = 0;
    int n_stop = 0;
    int n_bytes = 0;
    int cyc = 0;
    logic [7:0] last_byte = '0;
    logic       oe_seen = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_hs_slave #(.DEV_ADDR(ADDR)) u_i2c_hs_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_write (addr_write),
        .hs_mode    (hs_mode)
    );

    // Output monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_evt) n_start++;
            if (stop_evt) n_stop++;
            if (byte_valid) begin
                n_bytes++;
                last_byte = byte_data;
            end
            if (sda_oe) oe_seen = 1'b1;
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clk(HALF);
        scl = 1'b1;   wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl = 1'b0;   wait_clk(HALF);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_clk(HALF);
        scl = 1'b1;   wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    // Send eight bits then clock the ninth; ack=1 when SDA was low mid-high
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(HALF);
            scl = 1'b1;   wait_clk(HALF);
            scl = 1'b0;
        end
        sda_m = 1'b1; wait_clk(HALF);
        scl = 1'b1;   wait_clk(HALF/2);
        ack = ~sda_line;
        wait_clk(HALF/2);
        scl = 1'b0;   wait_clk(HALF);
    endtask

    logic ack;
    int   nb0;
    int   ns0;

    initial begin
        // R10: reset state
        wait_clk(5);
        check("R10 reset sda_oe", sda_oe, 0);
        check("R10 reset byte_valid", byte_valid, 0);
        check("R10 reset hs_mode", hs_mode, 0);
        check("R10 reset addr_write", addr_write, 0);
        rst_n = 1'b1;
        wait_clk(10);
        check("R10 post-reset events", start_evt | stop_evt, 0);
        check("R10 post-reset byte_data", byte_data, 0);

        // R7/R5: table of write bytes, one transfer each
        for (int v = 0; v < NVEC; v++) begin
            nb0 = n_bytes;
            bus_start();
            send_byte({ADDR, 1'b0}, ack);
            check("R5 write address ack", ack, 1);
            check("R5 addr_write", addr_write, 1);
            send_byte(WR_VEC[v], ack);
            check("R7 data ack", ack, 1);
            check("R7 data byte", last_byte, WR_VEC[v]);
            check("R7 single delivery", n_bytes - nb0, 1);
            bus_stop();
        end

        // R1: event counts over the table transfers
        check("R1 start count", n_start, NVEC);
        check("R1 stop count", n_stop, NVEC);

        // R7: two bytes back to back in one transfer
        nb0 = n_bytes;
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack);
        check("R7 burst second ack", ack, 1);
        check("R7 burst last byte", last_byte, 8'h34);
        check("R7 burst count", n_bytes - nb0, 2);
        bus_stop();

        // R6: foreign address, then a byte that must be ignored
        nb0 = n_bytes;
        bus_start();
        send_byte({7'h3D, 1'b0}, ack);
        check("R6 foreign address no ack", ack, 0);
        check("R6 addr_write low", addr_write, 0);
        send_byte(8'h77, ack);
        check("R6 ignored byte no ack", ack, 0);
        check("R6 ignored byte not delivered", n_bytes - nb0, 0);
        bus_stop();

        // R2/R3/R4: master code, repeated START, write in high-speed mode
        bus_start();
        oe_seen = 1'b0;
        send_byte(8'b0000_1101, ack);
        check("R2 master code nack", ack, 0);
        check("R2 sda_oe never driven", oe_seen, 0);
        check("R3 hs_mode after master code", hs_mode, 1);
        ns0 = n_start;
        bus_start();
        check("R1 repeated start event", n_start - ns0, 1);
        check("R4 hs_mode after repeated start", hs_mode, 1);
        nb0 = n_bytes;
        send_byte({ADDR, 1'b0}, ack);
        check("R5 hs address ack", ack, 1);
        send_byte(8'hC3, ack);
        check("R7 hs data byte", last_byte, 8'hC3);
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        check("R4 hs_mode after second repeated start", hs_mode, 1);
        bus_stop();
        wait_clk(5);
        check("R4 hs_mode cleared by stop", hs_mode, 0);

        // R2: master code with other low bits, also unacknowledged
        bus_start();
        send_byte(8'b0000_1000, ack);
        check("R2 master code 08 nack", ack, 0);
        check("R3 hs_mode set again", hs_mode, 1);
        bus_stop();
        wait_clk(5);
        check("R4 stop clears again", hs_mode, 0);

        // R8: read address acked, then SDA left released
        nb0 = n_bytes;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check("R8 read address ack", ack, 1);
        check("R8 addr_write low", addr_write, 0);
        oe_seen = 1'b0;
        send_byte(8'hFF, ack);
        check("R8 no drive after read ack", oe_seen, 0);
        check("R8 no delivery", n_bytes - nb0, 0);
        bus_stop();

        wait_clk(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule